// File: doc/BRIEF.md
# Masked Alarm Time Comparator

This block watches a six-byte BCD time-of-day counter chain and raises an alarm when the time reaches a programmed value. Software loads six compare bytes through a small register bus. It then picks which of them take part in the comparison and decides whether the alarm may drive the external interrupt request. Compare bytes that are not selected count as always equal. A partial-field alarm therefore needs only the fields that matter: a daily alarm, for instance, loads hours and minutes and selects only those. A deselected byte keeps its storage, so it serves as a general-purpose byte.

The counter chain presents its six bytes together with a one-cycle update strobe. Byte 0 holds hundredths, byte 1 seconds, byte 2 minutes, byte 3 hours, byte 4 day and byte 5 month. The comparison is made only in strobe cycles. The alarm flag sets once for each new match and stays set until software writes a one to the clear bit of the status port.

Top module: `alarm_cmp_top`

## Requirements
- R1: Bus addresses 0 to 5 hold compare bytes 0 to 5. A bus write stores the data, and a combinational read returns the stored byte whether or not that byte is selected for comparison.
- R2: Bus address 6 is the control byte. Bit k (k = 0..5) selects compare byte k, and bit 7 enables the interrupt request. Bit 6 reads back as zero. The byte reads back through the bus.
- R3: After reset all compare bytes and the control byte are zero, alarm_flag_o is 0 and irq_o is 0.
- R4: In a cycle with cnt_tick_i high, a match exists when every selected compare byte equals its counter byte. Deselected bytes count as equal. On a new match, alarm_flag_o is 1 from the following clock edge.
- R5: If any selected byte differs from its counter byte in the strobe cycle, the flag does not set.
- R6: With no compare byte selected, the flag never sets.
- R7: The flag sets whatever the state of the interrupt enable. irq_o is high exactly while the flag is set and control bit 7 is 1.
- R8: A status write (stat_we_i) with stat_wdata_i bit 3 = 1 clears the flag at the next edge. A status write with bit 3 = 0 leaves the flag unchanged.
- R9: A match seen at consecutive strobes sets the flag only at the first of them. After a clear, the flag sets again only after a strobe without a match has come in between.
- R10: Counter values that match while cnt_tick_i is low do not set the flag.
- R11: When a new match and a clear fall in the same cycle, the flag ends up set.
- R12: Bus address 7 reads as zero, and writes to it change no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register bus write strobe |
| bus_addr_i | input | 3 | Register bus address |
| bus_wdata_i | input | 8 | Register bus write data |
| bus_rdata_o | output | 8 | Register bus read data, combinational from address |
| stat_we_i | input | 1 | Status port write strobe |
| stat_wdata_i | input | 8 | Status write data; bit 3 clears the flag |
| cnt_i | input | 48 | Counter chain bytes, byte 0 in bits 7:0 |
| cnt_tick_i | input | 1 | Counter update strobe, one cycle per new value |
| alarm_flag_o | output | 1 | Alarm status flag |
| irq_o | output | 1 | Qualified alarm interrupt request |

## Verification
The assertions assume that cnt_tick_i is high for a single cycle for each counter value and that cnt_i is valid in that cycle. They also assume that status and bus writes last one cycle each. The bench changes every input half a period away from the active edge. It holds the counter bytes steady between strobes and pulses the strobe for one cycle only. Before each table vector it sends a strobe whose counter bytes are all FF, which no BCD compare byte can equal, so the edge-detection history always starts from a known state.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;
  localparam int unsigned CLR_BIT = 3;

  typedef enum logic [1:0] {
    SEL_CMP,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BYTE_W-1:0]           bus_wdata_i,
  output logic [BYTE_W-1:0]           bus_rdata_o,
  output logic [NUM_BYTES*BYTE_W-1:0] cmp_o,
  output logic [NUM_BYTES-1:0]        en_o,
  output logic                        irq_en_o
);
  localparam int unsigned CTRL_ADDR = NUM_BYTES;
  localparam int unsigned IRQ_BIT   = BYTE_W - 1;

  logic [BYTE_W-1:0]    cmp_q [NUM_BYTES];
  logic [NUM_BYTES-1:0] en_q;
  logic                 irq_en_q;
  reg_sel_e             sel;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr_i < ADDR_W'(NUM_BYTES)) sel = SEL_CMP;
    else if (bus_addr_i == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
  end

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q[i] <= '0;
      else if (bus_we_i && sel == SEL_CMP && bus_addr_i == ADDR_W'(i))
        cmp_q[i] <= bus_wdata_i;
    end
    assign cmp_o[i*BYTE_W +: BYTE_W] = cmp_q[i];

    AST_CMP_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_we_i && bus_addr_i == ADDR_W'(i) |=> cmp_q[i] == $past(bus_wdata_i)); // R1
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= '0;
      irq_en_q <= 1'b0;
    end else if (bus_we_i && sel == SEL_CTRL) begin
      en_q     <= bus_wdata_i[NUM_BYTES-1:0];
      irq_en_q <= bus_wdata_i[IRQ_BIT];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (sel)
      SEL_CMP: begin
        for (int i = 0; i < NUM_BYTES; i++)
          if (bus_addr_i == ADDR_W'(i)) bus_rdata_o = cmp_q[i];
      end
      SEL_CTRL: begin
        bus_rdata_o[NUM_BYTES-1:0] = en_q;
        bus_rdata_o[IRQ_BIT]       = irq_en_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign en_o     = en_q;
  assign irq_en_o = irq_en_q;

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_we_i && bus_addr_i == ADDR_W'(CTRL_ADDR)) |=> $stable(en_q) && $stable(irq_en_q)); // R2
endmodule

// File: rtl/alarm_match.sv
module alarm_match #(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned BYTE_W    = 8
) (
  input  logic [NUM_BYTES*BYTE_W-1:0] cnt_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] cmp_i,
  input  logic [NUM_BYTES-1:0]        en_i,
  output logic                        hit_o
);
  logic [NUM_BYTES-1:0] eq_vec;

  // deselected byte acts as always equal
  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_cmp
    assign eq_vec[i] = !en_i[i] ||
                       (cnt_i[i*BYTE_W +: BYTE_W] == cmp_i[i*BYTE_W +: BYTE_W]);
  end

  // no byte selected: never match
  assign hit_o = (&eq_vec) && (|en_i);
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic prev_q;
  logic flag_q;
  logic set;

  assign set = tick_i && hit_i && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else if (tick_i) prev_q <= hit_i;
  end

  // set beats clear so a fresh event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && irq_en_i;

  AST_SET_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && hit_i && !prev_q |=> flag_o); // R4
  AST_NO_SET_OFF_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !flag_o |=> !flag_o); // R10
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !tick_i |=> !flag_o); // R8
  AST_HELD_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && prev_q && !flag_o |=> !flag_o); // R9
endmodule

// File: rtl/alarm_cmp_top.sv
module alarm_cmp_top
  import alarm_cmp_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_we_i,
  input  logic [ADDR_W-1:0]           bus_addr_i,
  input  logic [BYTE_W-1:0]           bus_wdata_i,
  output logic [BYTE_W-1:0]           bus_rdata_o,
  input  logic                        stat_we_i,
  input  logic [BYTE_W-1:0]           stat_wdata_i,
  input  logic [NUM_BYTES*BYTE_W-1:0] cnt_i,
  input  logic                        cnt_tick_i,
  output logic                        alarm_flag_o,
  output logic                        irq_o
);
  logic [NUM_BYTES*BYTE_W-1:0] cmp;
  logic [NUM_BYTES-1:0]        en;
  logic                        irq_en;
  logic                        hit;
  logic                        clr;
  logic                        unused_stat;

  assign clr         = stat_we_i && stat_wdata_i[CLR_BIT];
  assign unused_stat = ^stat_wdata_i;

  alarm_regs #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cmp_o       (cmp),
    .en_o        (en),
    .irq_en_o    (irq_en)
  );

  alarm_match #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_match (
    .cnt_i (cnt_i),
    .cmp_i (cmp),
    .en_i  (en),
    .hit_o (hit)
  );

  alarm_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (cnt_tick_i),
    .hit_i    (hit),
    .clr_i    (clr),
    .irq_en_i (irq_en),
    .flag_o   (alarm_flag_o),
    .irq_o    (irq_o)
  );

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> alarm_flag_o); // R7
  AST_NO_ALARM_ALL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(en) != '0); // R6
  AST_SET_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alarm_flag_o) |-> $past(cnt_tick_i)); // R10
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_flag_o && !clr |=> alarm_flag_o); // R8
endmodule

// File: tb/sim_alarm_cmp_top.sv
`timescale 1ns/1ps
module sim_alarm_cmp_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        stat_we = 1'b0;
  logic [7:0]  stat_wdata = '0;
  logic [47:0] cnt = '0;
  logic        tick = 1'b0;
  logic        flag;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  alarm_cmp_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .stat_we_i(stat_we),
    .stat_wdata_i(stat_wdata), .cnt_i(cnt), .cnt_tick_i(tick),
    .alarm_flag_o(flag), .irq_o(irq)
  );

  // {expected flag, enables[5:0], counter {mon,day,hr,min,sec,hs}}
  localparam logic [54:0] VEC [10] = '{
    {1'b1, 6'h0F, 48'h12_05_03_15_00_00},
    {1'b0, 6'h0F, 48'h01_01_03_14_59_99},
    {1'b1, 6'h0C, 48'h07_09_03_15_42_17},
    {1'b1, 6'h3F, 48'h12_21_03_15_00_00},
    {1'b0, 6'h3F, 48'h12_22_03_15_00_00},
    {1'b0, 6'h00, 48'h12_21_03_15_00_00},
    {1'b1, 6'h08, 48'h01_01_03_59_59_99},
    {1'b1, 6'h01, 48'h05_30_23_07_44_00},
    {1'b0, 6'h20, 48'h11_21_03_15_00_00},
    {1'b0, 6'h0C, 48'h12_21_13_15_00_00}
  };
  localparam logic [7:0] CMPV [6] = '{8'h00, 8'h00, 8'h15, 8'h03, 8'h21, 8'h12};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic stat_wr(input logic [7:0] d);
    @(negedge clk); stat_we = 1'b1; stat_wdata = d;
    @(negedge clk); stat_we = 1'b0;
  endtask

  task automatic do_tick(input logic [47:0] c);
    @(negedge clk); cnt = c; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic fresh();
    stat_wr(8'h08);
    do_tick(48'hFFFF_FFFF_FFFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk("R3 flag", flag, 0);
    chk("R3 irq", irq, 0);
    bus_rd(3'd6, rd); chk("R3 ctrl", rd, 8'h00);
    bus_rd(3'd3, rd); chk("R3 cmp", rd, 8'h00);
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) bus_wr(3'(i), CMPV[i]);
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'(i), rd); chk("R1 readback deselected", rd, CMPV[i]);
    end

    for (int v = 0; v < 10; v++) begin
      bus_wr(3'd6, {2'b00, VEC[v][53:48]});
      fresh();
      do_tick(VEC[v][47:0]);
      chk($sformatf("R4/R5/R6 vec %0d", v), flag, VEC[v][54]);
      chk("R7 irq off", irq, 0);
    end

    // R2 readback
    bus_wr(3'd6, 8'hC8);
    bus_rd(3'd6, rd); chk("R2 ctrl readback", rd, 8'h88);
    bus_wr(3'd6, 8'h08);

    // R9 held match
    fresh();
    do_tick(48'h01_01_03_00_00_00); chk("R9 first", flag, 1);
    stat_wr(8'h08);                 chk("R8 clear", flag, 0);
    do_tick(48'h01_01_03_00_00_01); chk("R9 held no reset", flag, 0);
    do_tick(48'h01_01_04_00_00_00); chk("R9 mismatch", flag, 0);
    do_tick(48'h01_01_03_00_00_00); chk("R9 rearm", flag, 1);

    // R11 set beats clear
    fresh();
    @(negedge clk); cnt = 48'h01_01_03_00_00_00; tick = 1'b1;
    stat_we = 1'b1; stat_wdata = 8'h08;
    @(negedge clk); tick = 1'b0; stat_we = 1'b0;
    chk("R11 set wins", flag, 1);

    // R10 no strobe
    fresh();
    @(negedge clk); cnt = 48'h01_01_03_00_00_00;
    repeat (3) @(negedge clk);
    chk("R10 no tick", flag, 0);

    // R7 interrupt qualification
    do_tick(48'h01_01_03_00_00_00);
    chk("R7 flag irq off", flag, 1);
    chk("R7 irq off", irq, 0);
    bus_wr(3'd6, 8'h88);
    chk("R7 irq on", irq, 1);

    // R8 zero write
    stat_wr(8'hF7); chk("R8 zero write flag", flag, 1);
    chk("R8 zero write irq", irq, 1);
    stat_wr(8'h08); chk("R8 one write", flag, 0);
    chk("R7 irq follows", irq, 0);

    // R12 unmapped
    bus_wr(3'd7, 8'hAB);
    bus_rd(3'd7, rd); chk("R12 unmapped read", rd, 8'h00);
    for (int i = 0; i < 6; i++) begin
      bus_rd(3'(i), rd); chk("R12 storage intact", rd, CMPV[i]);
    end
    bus_rd(3'd6, rd); chk("R12 ctrl intact", rd, 8'h88);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule